// File: doc/BRIEF.md
# Link Descriptor Pipeline Supervisor

This block supervises the buffer-descriptor flow between a framed serial link core and two frame rings, one for the receive direction and one for the transmit direction. Each direction runs its own four-state machine (idle, boot, run, recover). While running, it hands the link core descriptors that each name one 16-frame multiframe, and it takes back the descriptors the core has completed. It keeps at most four descriptors outstanding per direction.

The ring pointer arithmetic sits outside. The supervisor sees a level input from each ring: free frames on the receive side, unseen frames on the transmit side. It also sees the ring's current frame offset. It returns single-cycle strobes. On receive, a descriptor push also allocates 16 frames in the ring, and a retire commits 16 frames. On transmit, a push peeks 16 frames and a retire discards 16 frames. The receive side watches alignment and overflow, and the transmit side watches underflow. Either fault sends that direction into recovery. The supervisor clears the fault with a one-cycle strobe when the direction goes back to run. Four saturating counters record CRC, alignment, overflow and underflow events.

Transmit does not start until five multiframes (80 frames) are buffered, and the same rule applies after an underflow. Receive recovery first waits for all outstanding descriptors to come back. It then tells the ring to drop back to its last multiframe boundary.

Top module: `e1sup_top`

## Requirements
- R1: After reset both direction states read IDLE (code 0), both in-flight counts read 0 and all four error counters read 0.
- R2: A direction in IDLE ignores its done, status and level inputs: it produces no retire, push or clear strobe. It moves to BOOT (code 1) at the next edge after its enable input is high.
- R3: In a non-IDLE state with a nonzero in-flight count, a high done input gives a retire strobe in the same cycle. The in-flight count drops by one at the next edge. A done input with an in-flight count of 0 is ignored. A retire takes priority over every other action of that direction in that cycle.
- R4: On a receive retire, the CRC counter increments unless both CRC-ok bits (bit 0 for the first half multiframe, bit 1 for the second) are 1.
- R5: In receive RUN (code 2) without a retire, low alignment moves the state to RECOVER (code 3) and increments the alignment counter. High overflow with alignment present does the same and increments the overflow counter instead. Alignment is tested first.
- R6: Receive RECOVER stays put while the in-flight count is nonzero. Once the count is 0, it pulses the flush strobe and the overflow-clear strobe together and enters RUN at the next edge. Receive BOOT pulses overflow-clear and enters RUN at the next edge.
- R7: In RUN, with no retire and no fault, an in-flight count below 4 and a ring level of at least 16 produce a push strobe in the same cycle. The ring level is free frames on receive and unseen frames on transmit. The descriptor index output equals the ring frame offset shifted right by 4. The in-flight count rises by one at the next edge.
- R8: The in-flight count of a direction never exceeds 4. With 4 outstanding, no push is made.
- R9: Transmit BOOT and RECOVER stay put until the unseen level is at least 80. In that cycle they pulse underflow-clear and enter RUN at the next edge.
- R10: In transmit RUN without a retire, high underflow moves the state to RECOVER and increments the underflow counter.
- R11: Each error counter saturates at its all-ones value (7 with 3-bit counters) instead of wrapping.
- R12: In any cycle a direction raises at most one of its retire, push and clear strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Starts the receive direction from IDLE |
| tx_enable | input | 1 | Starts the transmit direction from IDLE |
| rx_aligned | input | 1 | Receive framer is aligned |
| rx_overflow | input | 1 | Receive overflow status from the link core |
| tx_underflow | input | 1 | Transmit underflow status from the link core |
| rx_done_valid | input | 1 | A completed receive descriptor is presented |
| rx_done_crc_ok | input | 2 | CRC-ok flags of the completed receive descriptor |
| tx_done_valid | input | 1 | A completed transmit descriptor is presented |
| rx_free_frames | input | LVL_W | Unallocated frames in the receive ring |
| rx_wr_ofs | input | OFS_W | Receive ring allocation offset, in frames |
| tx_unseen_frames | input | LVL_W | Buffered, not yet peeked frames in the transmit ring |
| tx_rd_ofs | input | OFS_W | Transmit ring peek offset, in frames |
| rx_retire | output | 1 | Pops the receive done descriptor and commits 16 frames |
| tx_retire | output | 1 | Pops the transmit done descriptor and discards 16 frames |
| rx_bd_push | output | 1 | Queues a receive descriptor and allocates 16 frames |
| rx_bd_mf | output | OFS_W-4 | Multiframe index of the queued receive descriptor |
| tx_bd_push | output | 1 | Queues a transmit descriptor and peeks 16 frames |
| tx_bd_mf | output | OFS_W-4 | Multiframe index of the queued transmit descriptor |
| rx_flush | output | 1 | Drops the receive ring back to its multiframe boundary |
| rx_ovfl_clr | output | 1 | Clears the overflow status in the link core |
| tx_unfl_clr | output | 1 | Clears the underflow status in the link core |
| rx_state | output | 2 | Receive state code |
| tx_state | output | 2 | Transmit state code |
| rx_inflight | output | 3 | Outstanding receive descriptors |
| tx_inflight | output | 3 | Outstanding transmit descriptors |
| crc_err_cnt | output | CNT_W | Saturating CRC error count |
| align_err_cnt | output | CNT_W | Saturating alignment loss count |
| ovfl_err_cnt | output | CNT_W | Saturating overflow count |
| unfl_err_cnt | output | CNT_W | Saturating underflow count |

## Verification
All strobes and descriptor indices are combinational from the registered state and the current inputs, so each is due in the same cycle as its stimulus. The bench drives inputs 1 ns after a rising edge and samples the strobes 1 ns later, still before the next edge. State codes, in-flight counts and error counters are registered and are due one edge later, so the bench reads them 1 ns after the following edge. The sweeps step the levels one value per cycle across the 16-frame and 80-frame thresholds. They also cover every CRC flag pattern and keep faults high long enough to drive the counters into saturation.

// File: rtl/e1sup_pkg.sv
package e1sup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BOOT    = 2'd1,
        ST_RUN     = 2'd2,
        ST_RECOVER = 2'd3
    } dir_state_e;

    localparam int unsigned NUM_ERR_CNT = 4;
    localparam int unsigned ERR_CRC     = 0;
    localparam int unsigned ERR_ALIGN   = 1;
    localparam int unsigned ERR_OVFL    = 2;
    localparam int unsigned ERR_UNFL    = 3;

endpackage

// File: rtl/e1sup_sat_cnt.sv
module e1sup_sat_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    assert_cnt_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    assert_cnt_steps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/e1sup_rx_ctrl.sv
module e1sup_rx_ctrl
    import e1sup_pkg::*;
#(
    parameter int unsigned OFS_W        = 7,
    parameter int unsigned LVL_W        = 8,
    parameter int unsigned MF_FRAMES    = 16,
    parameter int unsigned MAX_INFLIGHT = 4,
    localparam int unsigned MF_SH       = $clog2(MF_FRAMES),
    localparam int unsigned MF_W        = OFS_W - MF_SH,
    localparam int unsigned IF_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             aligned,
    input  logic             overflow,
    input  logic             done_valid,
    input  logic [1:0]       done_crc_ok,
    input  logic [LVL_W-1:0] free_frames,
    input  logic [OFS_W-1:0] wr_ofs,
    output logic             retire,
    output logic             bd_push,
    output logic [MF_W-1:0]  bd_mf,
    output logic             flush,
    output logic             ovfl_clr,
    output logic             crc_inc,
    output logic             align_inc,
    output logic             ovfl_inc,
    output logic [1:0]       state,
    output logic [IF_W-1:0]  inflight
);

    typedef struct packed {
        dir_state_e      st;
        logic [IF_W-1:0] infl;
    } rx_reg_t;

    rx_reg_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        retire    = 1'b0;
        bd_push   = 1'b0;
        flush     = 1'b0;
        ovfl_clr  = 1'b0;
        crc_inc   = 1'b0;
        align_inc = 1'b0;
        ovfl_inc  = 1'b0;
        if (rx_q.st != ST_IDLE && done_valid && rx_q.infl != '0) begin
            retire    = 1'b1;
            rx_d.infl = rx_q.infl - IF_W'(1);
            crc_inc   = (done_crc_ok != 2'b11);
        end else begin
            unique case (rx_q.st)
                ST_IDLE: begin
                    if (enable) rx_d.st = ST_BOOT;
                end
                ST_BOOT: begin
                    ovfl_clr = 1'b1;
                    rx_d.st  = ST_RUN;
                end
                ST_RUN: begin
                    if (!aligned) begin
                        rx_d.st   = ST_RECOVER;
                        align_inc = 1'b1;
                    end else if (overflow) begin
                        rx_d.st  = ST_RECOVER;
                        ovfl_inc = 1'b1;
                    end else if (rx_q.infl < IF_W'(MAX_INFLIGHT) &&
                                 free_frames >= LVL_W'(MF_FRAMES)) begin
                        bd_push   = 1'b1;
                        rx_d.infl = rx_q.infl + IF_W'(1);
                    end
                end
                ST_RECOVER: begin
                    if (rx_q.infl == '0) begin
                        flush    = 1'b1;
                        ovfl_clr = 1'b1;
                        rx_d.st  = ST_RUN;
                    end
                end
                default: rx_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q.st   <= ST_IDLE;
            rx_q.infl <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign bd_mf    = MF_W'(wr_ofs >> MF_SH);
    assign state    = rx_q.st;
    assign inflight = rx_q.infl;

    assert_rx_inflight_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.infl <= IF_W'(MAX_INFLIGHT));

    assert_rx_retire_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (rx_q.infl == $past(rx_q.infl) - IF_W'(1)));

    assert_rx_flush_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (rx_q.infl == '0 && rx_q.st == ST_RECOVER));

    assert_rx_align_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == ST_RUN && !retire && !aligned) |=> (rx_q.st == ST_RECOVER));

    assert_rx_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retire, bd_push, ovfl_clr}));

endmodule

// File: rtl/e1sup_tx_ctrl.sv
module e1sup_tx_ctrl
    import e1sup_pkg::*;
#(
    parameter int unsigned OFS_W        = 7,
    parameter int unsigned LVL_W        = 8,
    parameter int unsigned MF_FRAMES    = 16,
    parameter int unsigned MAX_INFLIGHT = 4,
    parameter int unsigned PREFILL_MF   = 5,
    localparam int unsigned MF_SH       = $clog2(MF_FRAMES),
    localparam int unsigned MF_W        = OFS_W - MF_SH,
    localparam int unsigned IF_W        = $clog2(MAX_INFLIGHT + 1),
    localparam int unsigned PREFILL     = MF_FRAMES * PREFILL_MF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             underflow,
    input  logic             done_valid,
    input  logic [LVL_W-1:0] unseen_frames,
    input  logic [OFS_W-1:0] rd_ofs,
    output logic             retire,
    output logic             bd_push,
    output logic [MF_W-1:0]  bd_mf,
    output logic             unfl_clr,
    output logic             unfl_inc,
    output logic [1:0]       state,
    output logic [IF_W-1:0]  inflight
);

    typedef struct packed {
        dir_state_e      st;
        logic [IF_W-1:0] infl;
    } tx_reg_t;

    tx_reg_t tx_d, tx_q;
    logic    prefilled;

    assign prefilled = (unseen_frames >= LVL_W'(PREFILL));

    always_comb begin
        tx_d     = tx_q;
        retire   = 1'b0;
        bd_push  = 1'b0;
        unfl_clr = 1'b0;
        unfl_inc = 1'b0;
        if (tx_q.st != ST_IDLE && done_valid && tx_q.infl != '0) begin
            retire    = 1'b1;
            tx_d.infl = tx_q.infl - IF_W'(1);
        end else begin
            unique case (tx_q.st)
                ST_IDLE: begin
                    if (enable) tx_d.st = ST_BOOT;
                end
                ST_BOOT, ST_RECOVER: begin
                    if (prefilled) begin
                        unfl_clr = 1'b1;
                        tx_d.st  = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (underflow) begin
                        tx_d.st  = ST_RECOVER;
                        unfl_inc = 1'b1;
                    end else if (tx_q.infl < IF_W'(MAX_INFLIGHT) &&
                                 unseen_frames >= LVL_W'(MF_FRAMES)) begin
                        bd_push   = 1'b1;
                        tx_d.infl = tx_q.infl + IF_W'(1);
                    end
                end
                default: tx_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q.st   <= ST_IDLE;
            tx_q.infl <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign bd_mf    = MF_W'(rd_ofs >> MF_SH);
    assign state    = tx_q.st;
    assign inflight = tx_q.infl;

    assert_tx_inflight_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.infl <= IF_W'(MAX_INFLIGHT));

    assert_tx_clear_needs_prefill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unfl_clr |=> (tx_q.st == ST_RUN && $past(unseen_frames) >= LVL_W'(PREFILL)));

    assert_tx_underflow_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.st == ST_RUN && !retire && underflow) |=> (tx_q.st == ST_RECOVER));

    assert_tx_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retire, bd_push, unfl_clr}));

endmodule

// File: rtl/e1sup_top.sv
module e1sup_top
    import e1sup_pkg::*;
#(
    parameter int unsigned OFS_W        = 7,
    parameter int unsigned LVL_W        = 8,
    parameter int unsigned MF_FRAMES    = 16,
    parameter int unsigned MAX_INFLIGHT = 4,
    parameter int unsigned PREFILL_MF   = 5,
    parameter int unsigned CNT_W        = 8,
    localparam int unsigned MF_W        = OFS_W - $clog2(MF_FRAMES),
    localparam int unsigned IF_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_enable,
    input  logic             tx_enable,
    input  logic             rx_aligned,
    input  logic             rx_overflow,
    input  logic             tx_underflow,
    input  logic             rx_done_valid,
    input  logic [1:0]       rx_done_crc_ok,
    input  logic             tx_done_valid,
    input  logic [LVL_W-1:0] rx_free_frames,
    input  logic [OFS_W-1:0] rx_wr_ofs,
    input  logic [LVL_W-1:0] tx_unseen_frames,
    input  logic [OFS_W-1:0] tx_rd_ofs,
    output logic             rx_retire,
    output logic             tx_retire,
    output logic             rx_bd_push,
    output logic [MF_W-1:0]  rx_bd_mf,
    output logic             tx_bd_push,
    output logic [MF_W-1:0]  tx_bd_mf,
    output logic             rx_flush,
    output logic             rx_ovfl_clr,
    output logic             tx_unfl_clr,
    output logic [1:0]       rx_state,
    output logic [1:0]       tx_state,
    output logic [IF_W-1:0]  rx_inflight,
    output logic [IF_W-1:0]  tx_inflight,
    output logic [CNT_W-1:0] crc_err_cnt,
    output logic [CNT_W-1:0] align_err_cnt,
    output logic [CNT_W-1:0] ovfl_err_cnt,
    output logic [CNT_W-1:0] unfl_err_cnt
);

    logic [NUM_ERR_CNT-1:0] err_inc;
    logic [CNT_W-1:0]       err_cnt [NUM_ERR_CNT];

    e1sup_rx_ctrl #(
        .OFS_W        (OFS_W),
        .LVL_W        (LVL_W),
        .MF_FRAMES    (MF_FRAMES),
        .MAX_INFLIGHT (MAX_INFLIGHT)
    ) rx_ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (rx_enable),
        .aligned     (rx_aligned),
        .overflow    (rx_overflow),
        .done_valid  (rx_done_valid),
        .done_crc_ok (rx_done_crc_ok),
        .free_frames (rx_free_frames),
        .wr_ofs      (rx_wr_ofs),
        .retire      (rx_retire),
        .bd_push     (rx_bd_push),
        .bd_mf       (rx_bd_mf),
        .flush       (rx_flush),
        .ovfl_clr    (rx_ovfl_clr),
        .crc_inc     (err_inc[ERR_CRC]),
        .align_inc   (err_inc[ERR_ALIGN]),
        .ovfl_inc    (err_inc[ERR_OVFL]),
        .state       (rx_state),
        .inflight    (rx_inflight)
    );

    e1sup_tx_ctrl #(
        .OFS_W        (OFS_W),
        .LVL_W        (LVL_W),
        .MF_FRAMES    (MF_FRAMES),
        .MAX_INFLIGHT (MAX_INFLIGHT),
        .PREFILL_MF   (PREFILL_MF)
    ) tx_ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (tx_enable),
        .underflow     (tx_underflow),
        .done_valid    (tx_done_valid),
        .unseen_frames (tx_unseen_frames),
        .rd_ofs        (tx_rd_ofs),
        .retire        (tx_retire),
        .bd_push       (tx_bd_push),
        .bd_mf         (tx_bd_mf),
        .unfl_clr      (tx_unfl_clr),
        .unfl_inc      (err_inc[ERR_UNFL]),
        .state         (tx_state),
        .inflight      (tx_inflight)
    );

    for (genvar gi = 0; gi < NUM_ERR_CNT; gi++) begin : g_err_cnt
        e1sup_sat_cnt #(
            .CNT_W (CNT_W)
        ) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (err_inc[gi]),
            .cnt   (err_cnt[gi])
        );
    end

    assign crc_err_cnt   = err_cnt[ERR_CRC];
    assign align_err_cnt = err_cnt[ERR_ALIGN];
    assign ovfl_err_cnt  = err_cnt[ERR_OVFL];
    assign unfl_err_cnt  = err_cnt[ERR_UNFL];

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == 2'd0 && tx_state == 2'd0) |->
        !(rx_retire || tx_retire || rx_bd_push || tx_bd_push ||
          rx_flush || rx_ovfl_clr || tx_unfl_clr));

endmodule

// File: tb/e1sup_top_tb_top.sv
`timescale 1ns/100ps
module e1sup_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 0, tx_enable = 0, rx_aligned = 0, rx_overflow = 0, tx_underflow = 0;
    logic       rx_done_valid = 0, tx_done_valid = 0;
    logic [1:0] rx_done_crc_ok = 0;
    logic [7:0] rx_free_frames = 0, tx_unseen_frames = 0;
    logic [6:0] rx_wr_ofs = 0, tx_rd_ofs = 0;
    logic       rx_retire, tx_retire, rx_bd_push, tx_bd_push, rx_flush, rx_ovfl_clr, tx_unfl_clr;
    logic [2:0] rx_bd_mf, tx_bd_mf, rx_inflight, tx_inflight;
    logic [1:0] rx_state, tx_state;
    logic [2:0] crc_err_cnt, align_err_cnt, ovfl_err_cnt, unfl_err_cnt;

    int checks = 0;
    int failures = 0;
    int exp_crc = 0;

    e1sup_top #(.CNT_W(3)) dut_i (.*);

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 rx_state", rx_state, 0);
        chk("R1 tx_state", tx_state, 0);
        chk("R1 rx_inflight", rx_inflight, 0);
        chk("R1 tx_inflight", tx_inflight, 0);
        chk("R1 counters", crc_err_cnt + align_err_cnt + ovfl_err_cnt + unfl_err_cnt, 0);

        // R2 idle ignores every input but enable
        rx_done_valid = 1; tx_done_valid = 1; rx_free_frames = 127; tx_unseen_frames = 127;
        rx_overflow = 1; tx_underflow = 1;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk("R2 idle strobes", rx_retire + tx_retire + rx_bd_push + tx_bd_push
                + rx_flush + rx_ovfl_clr + tx_unfl_clr, 0);
            tick();
            chk("R2 idle states", rx_state + tx_state, 0);
            chk("R2 idle counters", align_err_cnt + ovfl_err_cnt + unfl_err_cnt, 0);
        end
        rx_done_valid = 0; tx_done_valid = 0; rx_free_frames = 0; tx_unseen_frames = 0;
        rx_overflow = 0; tx_underflow = 0; rx_aligned = 1;

        rx_enable = 1;
        tick();
        chk("R2 rx boot", rx_state, 1);
        chk("R2 tx stays idle", tx_state, 0);
        #1 chk("R6 boot clear", rx_ovfl_clr, 1);
        tick();
        chk("R6 boot to run", rx_state, 2);

        // R7 queue with descriptor index, R8 cap
        rx_free_frames = 127;
        for (int k = 0; k < 5; k++) begin
            rx_wr_ofs = 7'(k * 32 + k);
            #1;
            chk("R7 R8 rx push", rx_bd_push, (k < 4) ? 1 : 0);
            if (k < 4) chk("R7 rx mf", rx_bd_mf, 2 * k);
            tick();
            chk("R8 rx inflight", rx_inflight, (k < 4) ? k + 1 : 4);
        end

        // R3 R4 retire with every CRC flag pattern, priority over push
        for (int p = 0; p < 4; p++) begin
            rx_done_valid = 1; rx_done_crc_ok = 2'(p);
            #1;
            chk("R3 rx retire", rx_retire, 1);
            chk("R12 no push on retire", rx_bd_push, 0);
            tick();
            if (p != 3) exp_crc++;
            chk("R3 rx inflight dec", rx_inflight, 3 - p);
            chk("R4 crc count", crc_err_cnt, exp_crc);
        end
        rx_free_frames = 0;
        #1 chk("R3 retire at zero ignored", rx_retire, 0);
        tick();
        chk("R3 inflight stays 0", rx_inflight, 0);
        chk("R4 crc unchanged", crc_err_cnt, exp_crc);
        rx_done_valid = 0;

        // R7 free-level threshold sweep
        for (int lv = 0; lv <= 16; lv++) begin
            rx_free_frames = 8'(lv);
            #1 chk("R7 level gate", rx_bd_push, (lv >= 16) ? 1 : 0);
            tick();
            chk("R7 inflight after gate", rx_inflight, (lv >= 16) ? 1 : 0);
        end
        rx_free_frames = 0;

        // R5 alignment loss, R6 recovery waits for drain
        rx_aligned = 0;
        tick();
        chk("R5 align to recover", rx_state, 3);
        chk("R5 align count", align_err_cnt, 1);
        for (int i = 0; i < 3; i++) begin
            #1 chk("R6 no flush while busy", rx_flush + rx_ovfl_clr, 0);
            tick();
            chk("R6 waits in recover", rx_state, 3);
        end
        rx_done_valid = 1; rx_done_crc_ok = 2'b11;
        tick();
        chk("R3 drained", rx_inflight, 0);
        rx_done_valid = 0; rx_aligned = 1;
        #1;
        chk("R6 flush", rx_flush, 1);
        chk("R6 clear", rx_ovfl_clr, 1);
        tick();
        chk("R6 back to run", rx_state, 2);

        // R5 alignment has priority over overflow
        rx_aligned = 0; rx_overflow = 1;
        tick();
        chk("R5 priority align", align_err_cnt, 2);
        chk("R5 priority ovfl", ovfl_err_cnt, 0);
        rx_aligned = 1;
        tick();
        chk("R6 run again", rx_state, 2);
        tick();
        chk("R5 overflow recover", rx_state, 3);
        chk("R5 overflow count", ovfl_err_cnt, 1);
        rx_overflow = 0;
        tick();
        chk("R6 overflow cleared", rx_state, 2);

        // R11 saturation: loss of alignment repeated, 8 more increments
        rx_aligned = 0;
        for (int i = 0; i < 16; i++) tick();
        chk("R11 align saturates", align_err_cnt, 7);
        rx_aligned = 1;
        tick();
        chk("R11 rx state after", rx_state, 2);

        // R9 transmit prefill sweep
        tx_enable = 1;
        tick();
        chk("R2 tx boot", tx_state, 1);
        for (int u = 0; u <= 80; u++) begin
            tx_unseen_frames = 8'(u);
            #1 chk("R9 prefill clear", tx_unfl_clr, (u >= 80) ? 1 : 0);
            tick();
            chk("R9 prefill state", tx_state, (u >= 80) ? 2 : 1);
        end

        // R7 R8 transmit queue
        for (int k = 0; k < 5; k++) begin
            tx_rd_ofs = 7'(k * 16 + 3);
            #1 chk("R7 R8 tx push", tx_bd_push, (k < 4) ? 1 : 0);
            if (k < 4) chk("R7 tx mf", tx_bd_mf, k);
            tick();
            chk("R8 tx inflight", tx_inflight, (k < 4) ? k + 1 : 4);
        end

        // R10 underflow, R9 recovery prefill
        tx_underflow = 1;
        tick();
        chk("R10 underflow recover", tx_state, 3);
        chk("R10 underflow count", unfl_err_cnt, 1);
        tx_underflow = 0; tx_unseen_frames = 79;
        #1 chk("R9 recover holds", tx_unfl_clr, 0);
        tick();
        chk("R9 recover state", tx_state, 3);
        tx_unseen_frames = 80;
        #1 chk("R9 recover clear", tx_unfl_clr, 1);
        tick();
        chk("R9 recover to run", tx_state, 2);

        // R3 R12 transmit retire wins over underflow
        tx_done_valid = 1; tx_underflow = 1;
        #1 chk("R3 tx retire", tx_retire, 1);
        tick();
        chk("R3 tx inflight dec", tx_inflight, 3);
        chk("R12 tx stays run", tx_state, 2);
        chk("R12 no underflow count", unfl_err_cnt, 1);
        tx_done_valid = 0; tx_underflow = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule